// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block runs a 16-line general-purpose port that two parties drive at once. Software drives it through a small register port, and internal peripherals drive it through a separate direction/value pair. A 32-bit control word holds two bits for each line: one selects software drive and the other enables a weak pull-up. A 16-bit data word holds the values that software drives. Each line's level is resolved from the software drive, the peripheral drive and the pull-up. Reading the data address returns these resolved levels, not the stored software values.

The block keeps the resolved levels from the previous cycle and compares them with the current ones. Four notification clients each own a programmable trigger mask. A client receives a one-cycle notification when a line covered by its mask has changed. Clients read the current levels on the `pin_lvl` output and may answer by changing the peripheral drive. Because the comparison runs every cycle, a change caused by that answer is detected the same way. A nonzero write to the port interrupt configuration word is an unsupported setting, and the block flags it with an error pulse.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, the control word, data word, interrupt configuration, trigger masks and registered peripheral drive are all zero. `pin_lvl` reads 0x0000, `notify` is 0 and `cfg_err` is 0.
- R2: Address 0 holds the control word. For line n, bit 2n set makes the line a software-driven output and bit 2n+1 set enables its pull-up. The word reads back as written.
- R3: Line n resolves to (sw_out AND data bit n) OR (peripheral dir bit n AND peripheral value bit n) OR (pull-up AND neither side driving). An undriven line with its pull-up disabled reads 0.
- R4: A read of address 1 (the data word) returns the resolved levels in bits 15:0 and zeros above them. A write to address 1 stores bits 15:0 as the software drive values.
- R5: A line driven by both software and a peripheral resolves to the OR of the two drive values.
- R6: Peripheral direction and value inputs are registered at each clock edge. When the resolved levels change between two consecutive cycles, each client i whose mask overlaps the changed set gets `notify[i]` high for exactly the following cycle.
- R7: If the resolved levels do not change, no notification is raised. This holds even after a register write, for example a write of the same value or a change of direction on a line whose level stays the same.
- R8: A level change caused only by the peripheral drive inputs notifies clients in the same way as one caused by a software write.
- R9: Address 2 is the port interrupt configuration word. A write of a nonzero value to it raises `cfg_err` for the one cycle after the write. A write of zero, or any other access, leaves `cfg_err` low.
- R10: Addresses 4 to 7 hold the trigger masks of clients 0 to 3 (bits 15:0). A read returns the mask in bits 15:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| per_dir | input | 16 | Peripheral drive enable per line |
| per_dat | input | 16 | Peripheral drive value per line |
| pin_lvl | output | 16 | Resolved line levels |
| notify | output | 4 | Per-client change notification pulse |
| cfg_err | output | 1 | Unsupported interrupt configuration pulse |

## Verification
A software data write and a change in the peripheral drive can land on the same clock edge. Each of them alters a different line. The bench provokes this by presenting the write strobe and the new peripheral value in the same cycle. It then checks that the resolved levels reflect both changes. It also checks that a single notification follows, covering every client whose mask overlaps either changed line, with no split into two pulses.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DAT   = 3'd1;
  localparam logic [ADDR_W-1:0] A_ICFG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK0 = 3'd4;

  // Level of one line from its two drivers and its pull-up.
  function automatic logic pin_level(logic sd, logic sv, logic pd, logic pv, logic pu);
    return (sd & sv) | (pd & pv) | (pu & ~sd & ~pd);
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int NCLI  = 4,
  localparam int CW   = 2 * NPINS
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [CW-1:0]         reg_wdata,
  output logic [CW-1:0]         reg_rdata,
  input  logic [NPINS-1:0]      per_dir,
  input  logic [NPINS-1:0]      per_dat,
  input  logic [NPINS-1:0]      lvl,
  output logic [NPINS-1:0]      sw_dir,
  output logic [NPINS-1:0]      sw_pu,
  output logic [NPINS-1:0]      sw_dat,
  output logic [NPINS-1:0]      pdir_q,
  output logic [NPINS-1:0]      pdat_q,
  output logic [NCLI*NPINS-1:0] masks,
  output logic                  cfg_err
);
  logic [CW-1:0]    ctl_r;
  logic [CW-1:0]    icfg_r;
  logic [NPINS-1:0] mask_r [NCLI];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_r   <= '0;
      sw_dat  <= '0;
      icfg_r  <= '0;
      pdir_q  <= '0;
      pdat_q  <= '0;
      cfg_err <= 1'b0;
      for (int i = 0; i < NCLI; i++) mask_r[i] <= '0;
    end else begin
      cfg_err <= 1'b0;
      pdir_q  <= per_dir;
      pdat_q  <= per_dat;
      if (reg_wr) begin
        if (reg_addr == A_CTL) ctl_r <= reg_wdata;
        if (reg_addr == A_DAT) sw_dat <= reg_wdata[NPINS-1:0];
        if (reg_addr == A_ICFG) begin
          icfg_r  <= reg_wdata;
          cfg_err <= |reg_wdata;
        end
        for (int i = 0; i < NCLI; i++)
          if (int'(reg_addr) == int'(A_MASK0) + i) mask_r[i] <= reg_wdata[NPINS-1:0];
      end
    end
  end

  // Interleaved control pairs: even bit drive enable, odd bit pull-up.
  for (genvar n = 0; n < NPINS; n++) begin : g_unpack
    assign sw_dir[n] = ctl_r[2*n];
    assign sw_pu[n]  = ctl_r[2*n+1];
  end

  for (genvar i = 0; i < NCLI; i++) begin : g_mask
    assign masks[i*NPINS +: NPINS] = mask_r[i];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CTL)  reg_rdata = ctl_r;
    if (reg_addr == A_DAT)  reg_rdata = {{(CW-NPINS){1'b0}}, lvl};
    if (reg_addr == A_ICFG) reg_rdata = icfg_r;
    for (int i = 0; i < NCLI; i++)
      if (int'(reg_addr) == int'(A_MASK0) + i) reg_rdata = {{(CW-NPINS){1'b0}}, mask_r[i]};
  end
endmodule

// File: rtl/gpio_resolve.sv
module gpio_resolve
  import gpio_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic [NPINS-1:0] sw_dir,
  input  logic [NPINS-1:0] sw_pu,
  input  logic [NPINS-1:0] sw_dat,
  input  logic [NPINS-1:0] pdir_q,
  input  logic [NPINS-1:0] pdat_q,
  output logic [NPINS-1:0] lvl
);
  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    assign lvl[n] = pin_level(sw_dir[n], sw_dat[n], pdir_q[n], pdat_q[n], sw_pu[n]);
  end
endmodule

// File: rtl/gpio_notify.sv
module gpio_notify #(
  parameter int NPINS = 16,
  parameter int NCLI  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NPINS-1:0]      lvl,
  input  logic [NCLI*NPINS-1:0] masks,
  output logic [NPINS-1:0]      chg_set,
  output logic [NCLI-1:0]       notify
);
  logic [NPINS-1:0] lvl_q;

  assign chg_set = lvl ^ lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  for (genvar i = 0; i < NCLI; i++) begin : g_cli
    always_ff @(posedge clk) begin
      if (rst) notify[i] <= 1'b0;
      else     notify[i] <= |(chg_set & masks[i*NPINS +: NPINS]);
    end
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int NCLI  = 4,
  localparam int CW   = 2 * NPINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  output logic [CW-1:0]     reg_rdata,
  input  logic [NPINS-1:0]  per_dir,
  input  logic [NPINS-1:0]  per_dat,
  output logic [NPINS-1:0]  pin_lvl,
  output logic [NCLI-1:0]   notify,
  output logic              cfg_err
);
  logic [NPINS-1:0]      sw_dir, sw_pu, sw_dat, pdir_q, pdat_q, chg_set;
  logic [NCLI*NPINS-1:0] masks;

  gpio_regs #(.NPINS(NPINS), .NCLI(NCLI)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .per_dir(per_dir), .per_dat(per_dat), .lvl(pin_lvl),
    .sw_dir(sw_dir), .sw_pu(sw_pu), .sw_dat(sw_dat),
    .pdir_q(pdir_q), .pdat_q(pdat_q), .masks(masks), .cfg_err(cfg_err)
  );

  gpio_resolve #(.NPINS(NPINS)) u_res (
    .sw_dir(sw_dir), .sw_pu(sw_pu), .sw_dat(sw_dat),
    .pdir_q(pdir_q), .pdat_q(pdat_q), .lvl(pin_lvl)
  );

  gpio_notify #(.NPINS(NPINS), .NCLI(NCLI)) u_ntf (
    .clk(clk), .rst(rst), .lvl(pin_lvl), .masks(masks),
    .chg_set(chg_set), .notify(notify)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 16,
  parameter int NCLI  = 4,
  localparam int CW   = 2 * NPINS
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  reg_wr,
  input logic [ADDR_W-1:0]     reg_addr,
  input logic [CW-1:0]         reg_wdata,
  input logic [CW-1:0]         reg_rdata,
  input logic [NPINS-1:0]      pin_lvl,
  input logic [NCLI-1:0]       notify,
  input logic                  cfg_err,
  input logic [NPINS-1:0]      sw_dir,
  input logic [NPINS-1:0]      sw_pu,
  input logic [NPINS-1:0]      pdir_q,
  input logic [NCLI*NPINS-1:0] masks
);
  logic [NPINS-1:0] seen_l;
  logic [NCLI-1:0]  ovl;

  always_ff @(posedge clk) begin
    if (rst) seen_l <= '0;
    else     seen_l <= pin_lvl;
  end

  for (genvar i = 0; i < NCLI; i++) begin : g_ovl
    assign ovl[i] = |((pin_lvl ^ seen_l) & masks[i*NPINS +: NPINS]);
    a_r6_notify_overlap: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> notify[i] == $past(ovl[i]));
  end

  a_r7_quiet_when_stable: assert property (@(posedge clk) disable iff (rst)
    (pin_lvl == seen_l) |=> notify == '0);

  a_r3_floating_low: assert property (@(posedge clk) disable iff (rst)
    (pin_lvl & ~sw_dir & ~pdir_q & ~sw_pu) == '0);

  a_r3_pullup_high: assert property (@(posedge clk) disable iff (rst)
    (~pin_lvl & ~sw_dir & ~pdir_q & sw_pu) == '0);

  a_r4_read_levels: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_DAT) |-> reg_rdata == {{(CW-NPINS){1'b0}}, pin_lvl});

  a_r9_err_raised: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_ICFG && reg_wdata != '0) |=> cfg_err);

  a_r9_err_quiet: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == A_ICFG && reg_wdata != '0) |=> !cfg_err);
endmodule

bind gpio_port_ctrl gpio_port_chk #(.NPINS(NPINS), .NCLI(NCLI)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_lvl(pin_lvl),
  .notify(notify), .cfg_err(cfg_err), .sw_dir(sw_dir), .sw_pu(sw_pu),
  .pdir_q(pdir_q), .masks(masks)
);

// File: tb/gpio_port_ctrl_test.sv
`timescale 1ns/1ps
module gpio_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] per_dir = '0, per_dat = '0, pin_lvl;
  logic [3:0]  notify;
  logic        cfg_err;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  gpio_port_ctrl uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_dir(per_dir),
    .per_dat(per_dat), .pin_lvl(pin_lvl), .notify(notify), .cfg_err(cfg_err)
  );

  always #2 clk = ~clk;

  // Stimulus: {control, sw data, per dir, per value}
  localparam logic [79:0] VEC [6] = '{
    {32'h0000_0000, 16'hFFFF, 16'h0000, 16'h0000},
    {32'h5555_5555, 16'hA5A5, 16'h0000, 16'h0000},
    {32'hAAAA_AAAA, 16'h0000, 16'h0000, 16'h0000},
    {32'hAAAA_AAAA, 16'h0000, 16'h00FF, 16'h000F},
    {32'h0000_5555, 16'h00F0, 16'h00FF, 16'h000F},
    {32'h9999_9999, 16'h0000, 16'h0F00, 16'h0300}
  };

  function automatic logic [15:0] expect_lvl(logic [31:0] c, logic [15:0] d,
                                             logic [15:0] pd, logic [15:0] pv);
    logic [15:0] r = '0;
    for (int b = 0; b < 16; b++) begin
      if (c[2*b] && d[b]) r[b] = 1'b1;
      if (pd[b] && pv[b]) r[b] = 1'b1;
      if (!c[2*b] && !pd[b] && c[2*b+1]) r[b] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; per_dir = '0; per_dat = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1: reset state
    chk("R1 lines", {16'h0, pin_lvl}, 32'h0);
    chk("R1 notify", {28'h0, notify}, 32'h0);
    chk("R1 err", {31'h0, cfg_err}, 32'h0);
    rd(3'd0, v); chk("R1 ctl", v, 32'h0);
    rd(3'd4, v); chk("R1 mask0", v, 32'h0);

    // R2 R3 R4 R5: resolution table
    for (int k = 0; k < 6; k++) begin
      logic [15:0] e;
      wr(3'd0, VEC[k][79:48]);
      wr(3'd1, {16'h0, VEC[k][47:32]});
      per_dir = VEC[k][31:16]; per_dat = VEC[k][15:0];
      @(negedge clk);
      e = expect_lvl(VEC[k][79:48], VEC[k][47:32], VEC[k][31:16], VEC[k][15:0]);
      chk("R3 R5 lines", {16'h0, pin_lvl}, {16'h0, e});
      rd(3'd1, v); chk("R4 data read", v, {16'h0, e});
    end
    rd(3'd0, v); chk("R2 ctl readback", v, 32'h9999_9999);

    // Notification tests
    do_reset();
    wr(3'd4, 32'h0001); wr(3'd5, 32'h00F0); wr(3'd6, 32'h8000); wr(3'd7, 32'hFFFF);
    rd(3'd5, v); chk("R10 mask1", v, 32'h0000_00F0);
    rd(3'd7, v); chk("R10 mask3", v, 32'h0000_FFFF);
    wr(3'd0, 32'h0000_0101);
    @(negedge clk); chk("R7 dir only", {28'h0, notify}, 32'h0);
    wr(3'd1, 32'h0001);
    @(negedge clk); chk("R6 bit0", {28'h0, notify}, 32'h9);
    @(negedge clk); chk("R6 one cycle", {28'h0, notify}, 32'h0);
    wr(3'd1, 32'h0010);
    @(negedge clk); chk("R6 bits0 4", {28'h0, notify}, 32'hB);
    wr(3'd1, 32'h0010);
    @(negedge clk); chk("R7 same value", {28'h0, notify}, 32'h0);
    wr(3'd0, 32'h8000_0101);
    chk("R3 pullup line15", {16'h0, pin_lvl}, 32'h0000_8010);
    @(negedge clk); chk("R6 pullup change", {28'h0, notify}, 32'hC);
    // R8: peripheral-only change
    @(negedge clk);
    per_dir = 16'h8000; per_dat = 16'h0000;
    @(negedge clk); chk("R8 lines", {16'h0, pin_lvl}, 32'h0000_0010);
    @(negedge clk); chk("R8 notify", {28'h0, notify}, 32'hC);
    // R6 R8: software write and peripheral change on the same edge
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0011; per_dat = 16'h8000;
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R8 merged lines", {16'h0, pin_lvl}, 32'h0000_8011);
    @(negedge clk); chk("R6 merged notify", {28'h0, notify}, 32'hD);
    @(negedge clk); chk("R6 merged single", {28'h0, notify}, 32'h0);

    // R9: configuration error
    wr(3'd2, 32'h0000_0001);
    chk("R9 err set", {31'h0, cfg_err}, 32'h1);
    @(negedge clk); chk("R9 err pulse", {31'h0, cfg_err}, 32'h0);
    wr(3'd2, 32'h0);
    chk("R9 zero ok", {31'h0, cfg_err}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule